// File: doc/BRIEF.md
# PWM Time-Base Counter with Per-Event Output Actions

This block produces one PWM output from a programmable time-base. A prescaler turns the system clock into a time-base tick. A counter steps once per tick against an active period value, in one of three modes: rising, falling, or rising-then-falling. It can also be held frozen. Four counter events drive the output through a small action table: the count reaching zero, reaching the period, or matching the compare value while rising or while falling. Each entry of the table holds, clears, sets or toggles the output. The same four events are also exported as one-clock strobes, so that other logic (a converter start trigger, for example) can use them.

Software-style register writes reach the block through simple write-enable ports. Period and compare writes land in shadow copies. These copies move into the active registers only when the counter arrives at zero, or at any time while the counter is frozen, so the waveform is never changed in the middle of a period. Mode, action table and prescale writes take effect on the next clock.

The counter is an explicit state machine with three states:
- `ST_FROZEN`: counter stopped.
- `ST_RISE`: the last step was upward.
- `ST_FALL`: the last step was downward.

Its transitions are:
- any state to `ST_FROZEN` when the mode is frozen.
- any state to `ST_RISE` on a tick in rising mode.
- any state to `ST_FALL` on a tick in falling mode.
- In rising-then-falling mode:
  - `ST_RISE` goes to `ST_FALL` on a tick at or above the period.
  - `ST_FALL` goes to `ST_RISE` on a tick at zero.
  - `ST_FROZEN` goes to `ST_RISE` on a tick at zero, and to `ST_FALL` on a tick elsewhere.

Top module: `pwm_timebase_aq`

## Requirements
- R1: While reset is held and right after it, the count is 0, the output is low, no event strobe is high, the mode is frozen and the tick divider is 2.
- R2: The tick comes every (2^A) × F system clocks. A is `div_wdata[2:0]`. F is 1 when `div_wdata[5:3]` is 0, and twice that field otherwise. Every event strobe follows a tick.
- R3: Mode code 0 (rising) counts 0 up to the period and then wraps to 0, so zero strobes come every (period + 1) ticks.
- R4: Mode code 1 (falling) counts from the period down to 0 and then reloads the period, so zero strobes come every (period + 1) ticks.
- R5: Mode code 2 (rising-then-falling) turns around at the period and at zero, so zero strobes come every 2 × period ticks. A compare match reached while falling raises only the falling-compare strobe. Mode code 3 freezes the counter.
- R6: `act_wdata` holds four 2-bit fields: zero event in [1:0], period event in [3:2], rising compare in [5:4], falling compare in [7:6]. In each field, 0 holds the output, 1 drives it low, 2 drives it high and 3 toggles it.
- R7: In rising mode with set-on-zero and clear-on-rising-compare, the output is high for exactly `compare` ticks out of every (period + 1). A compare above the period gives a constant high.
- R8: Period and compare writes take effect only from the next arrival of the count at zero, or at once while the counter is frozen.
- R9: When events coincide, the zero action is applied first, then the period action, then the compare action. The last non-hold action wins, and a hold action never overrides.
- R10: An event strobe is high during the single clock in which the count shows the new value. The output takes the resulting level one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prd_wr | input | 1 | Write strobe for the period shadow |
| prd_wdata | input | 16 | Period value |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_wdata | input | 16 | Compare value |
| mode_wr | input | 1 | Write strobe for the counter mode |
| mode_wdata | input | 2 | 0 rising, 1 falling, 2 rising-then-falling, 3 frozen |
| act_wr | input | 1 | Write strobe for the action table |
| act_wdata | input | 8 | Four 2-bit action fields (see R6) |
| div_wr | input | 1 | Write strobe for the prescale setting |
| div_wdata | input | 6 | Prescale exponent [2:0] and factor code [5:3] |
| pwm_out | output | 1 | PWM output |
| cnt_out | output | 16 | Current count |
| dir_up | output | 1 | High when the last step was upward |
| evt_zero | output | 1 | Count arrived at zero |
| evt_prd | output | 1 | Count arrived at the period |
| evt_cmp_up | output | 1 | Compare match while rising |
| evt_cmp_dn | output | 1 | Compare match while falling |

## Verification
A write is captured on the next clock edge. A tick is registered, and the count moves on the clock after that tick. The event strobes appear together with the new count, and the output level follows one clock after the strobe. Period and compare writes show only after the next wrap to zero. The bench drives inputs on falling edges and samples on falling edges. It measures duty by counting high cycles over whole periods after a settling delay, so that pipeline offsets cancel out. It measures rates as the number of clocks between two successive strobes. For the one-clock output delay and for shadow loading, it checks the count and the output at the strobe itself and again one clock later.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_FREEZE = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ST_FROZEN = 2'd0,
        ST_RISE   = 2'd1,
        ST_FALL   = 2'd2
    } tb_state_e;

    typedef struct packed {
        act_e on_cdn;
        act_e on_cup;
        act_e on_prd;
        act_e on_zero;
    } act_tbl_t;

    function automatic logic apply_act(input logic cur, input act_e a);
        logic r;
        case (a)
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_aq_prescale.sv
module pwm_aq_prescale #(
    parameter int A_W = 3,
    parameter int B_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_sel,
    input  logic [B_W-1:0] b_sel,
    output logic           tick
);
    localparam int MAX_A = 1 << ((1 << A_W) - 1);
    localparam int MAX_B = 2 * ((1 << B_W) - 1);
    localparam int DIV_W = $clog2(MAX_A * MAX_B + 1);

    logic [DIV_W-1:0] fa;
    logic [DIV_W-1:0] fb;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] pc_q;

    always_comb begin
        fa  = DIV_W'(1) << a_sel;
        fb  = (b_sel == '0) ? DIV_W'(1) : DIV_W'({b_sel, 1'b0});
        div = fa * fb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            tick <= 1'b0;
        end else if (pc_q >= div - DIV_W'(1)) begin
            pc_q <= '0;
            tick <= 1'b1;
        end else begin
            pc_q <= pc_q + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int A_W   = 3,
    parameter int B_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prd_wr,
    input  logic [CNT_W-1:0]   prd_wdata,
    input  logic               cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               act_wr,
    input  logic [7:0]         act_wdata,
    input  logic               div_wr,
    input  logic [A_W+B_W-1:0] div_wdata,
    input  logic               wrap_load,
    output cnt_mode_e          mode,
    output act_tbl_t           act_tbl,
    output logic [A_W-1:0]     a_sel,
    output logic [B_W-1:0]     b_sel,
    output logic [CNT_W-1:0]   prd_act,
    output logic [CNT_W-1:0]   cmp_act
);
    localparam int NSH = 2;

    logic [NSH-1:0]   sh_wr;
    logic [CNT_W-1:0] sh_wdata [NSH];
    logic [CNT_W-1:0] sh_rst   [NSH];
    logic [CNT_W-1:0] act_q    [NSH];
    logic             load_en;

    assign sh_wr       = {cmp_wr, prd_wr};
    assign sh_wdata[0] = prd_wdata;
    assign sh_wdata[1] = cmp_wdata;
    assign sh_rst[0]   = '1;
    assign sh_rst[1]   = '0;
    assign load_en     = (mode == MODE_FREEZE) || wrap_load;

    for (genvar g = 0; g < NSH; g++) begin : g_shadow
        logic [CNT_W-1:0] shadow_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= sh_rst[g];
                act_q[g] <= sh_rst[g];
            end else begin
                if (sh_wr[g])
                    shadow_q <= sh_wdata[g];
                if (load_en)
                    act_q[g] <= shadow_q;
            end
        end
    end

    assign prd_act = act_q[0];
    assign cmp_act = act_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= MODE_FREEZE;
            act_tbl <= '0;
            a_sel   <= '0;
            b_sel   <= B_W'(1);
        end else begin
            if (mode_wr)
                mode <= cnt_mode_e'(mode_wdata);
            if (act_wr)
                act_tbl <= act_tbl_t'(act_wdata);
            if (div_wr) begin
                a_sel <= div_wdata[A_W-1:0];
                b_sel <= div_wdata[A_W+B_W-1:A_W];
            end
        end
    end
endmodule

// File: rtl/pwm_aq_counter.sv
module pwm_aq_counter
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             rising,
    output logic             stepped,
    output logic             wrap_load
);
    tb_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             step_q, step_d;
    logic             go_up;

    assign go_up = (st_q == ST_RISE) ? (cnt_q < prd) : (cnt_q == '0);

    always_comb begin
        cnt_d  = cnt_q;
        st_d   = st_q;
        step_d = 1'b0;
        if (mode == MODE_FREEZE) begin
            st_d = ST_FROZEN;
        end else if (tick) begin
            step_d = 1'b1;
            unique case (mode)
                MODE_UP: begin
                    st_d  = ST_RISE;
                    cnt_d = (cnt_q >= prd) ? '0 : cnt_q + CNT_W'(1);
                end
                MODE_DOWN: begin
                    st_d  = ST_FALL;
                    cnt_d = (cnt_q == '0 || cnt_q > prd) ? prd : cnt_q - CNT_W'(1);
                end
                MODE_UPDOWN: begin
                    if (prd == '0) begin
                        st_d  = ST_RISE;
                        cnt_d = '0;
                    end else if (go_up) begin
                        st_d  = ST_RISE;
                        cnt_d = cnt_q + CNT_W'(1);
                    end else begin
                        st_d  = ST_FALL;
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                MODE_FREEZE: begin
                    st_d   = ST_FROZEN;
                    step_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_FROZEN;
            cnt_q  <= '0;
            step_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            step_q <= step_d;
        end
    end

    assign cnt       = cnt_q;
    assign rising    = (st_q == ST_RISE);
    assign stepped   = step_q;
    assign wrap_load = step_d && (cnt_d == '0);
endmodule

// File: rtl/pwm_aq_qualifier.sv
module pwm_aq_qualifier
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stepped,
    input  logic             rising,
    input  logic [CNT_W-1:0] prd_act,
    input  logic [CNT_W-1:0] cmp_act,
    input  act_tbl_t         act_tbl,
    output logic             evt_zero,
    output logic             evt_prd,
    output logic             evt_cup,
    output logic             evt_cdn,
    output logic             pwm
);
    logic hit_cmp;
    logic pwm_q, pwm_d;

    assign hit_cmp  = stepped && (cnt == cmp_act);
    assign evt_zero = stepped && (cnt == '0);
    assign evt_prd  = stepped && (cnt == prd_act);
    assign evt_cup  = hit_cmp && rising;
    assign evt_cdn  = hit_cmp && !rising;

    always_comb begin
        pwm_d = pwm_q;
        if (evt_zero) pwm_d = apply_act(pwm_d, act_tbl.on_zero);
        if (evt_prd)  pwm_d = apply_act(pwm_d, act_tbl.on_prd);
        if (evt_cup)  pwm_d = apply_act(pwm_d, act_tbl.on_cup);
        if (evt_cdn)  pwm_d = apply_act(pwm_d, act_tbl.on_cdn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_timebase_aq.sv
module pwm_timebase_aq
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int A_W   = 3,
    parameter int B_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prd_wr,
    input  logic [CNT_W-1:0]   prd_wdata,
    input  logic               cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               act_wr,
    input  logic [7:0]         act_wdata,
    input  logic               div_wr,
    input  logic [A_W+B_W-1:0] div_wdata,
    output logic               pwm_out,
    output logic [CNT_W-1:0]   cnt_out,
    output logic               dir_up,
    output logic               evt_zero,
    output logic               evt_prd,
    output logic               evt_cmp_up,
    output logic               evt_cmp_dn
);
    cnt_mode_e        mode_w;
    act_tbl_t         act_w;
    logic [A_W-1:0]   a_sel_w;
    logic [B_W-1:0]   b_sel_w;
    logic [CNT_W-1:0] prd_act_w;
    logic [CNT_W-1:0] cmp_act_w;
    logic             tick_w;
    logic             stepped_w;
    logic             rising_w;
    logic             wrap_w;

    pwm_aq_regs #(.CNT_W(CNT_W), .A_W(A_W), .B_W(B_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .act_wr(act_wr), .act_wdata(act_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .wrap_load(wrap_w),
        .mode(mode_w), .act_tbl(act_w),
        .a_sel(a_sel_w), .b_sel(b_sel_w),
        .prd_act(prd_act_w), .cmp_act(cmp_act_w)
    );

    pwm_aq_prescale #(.A_W(A_W), .B_W(B_W)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel_w), .b_sel(b_sel_w),
        .tick(tick_w)
    );

    pwm_aq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick(tick_w), .mode(mode_w), .prd(prd_act_w),
        .cnt(cnt_out), .rising(rising_w),
        .stepped(stepped_w), .wrap_load(wrap_w)
    );

    pwm_aq_qualifier #(.CNT_W(CNT_W)) u_aq (
        .clk(clk), .rst_n(rst_n),
        .cnt(cnt_out), .stepped(stepped_w), .rising(rising_w),
        .prd_act(prd_act_w), .cmp_act(cmp_act_w), .act_tbl(act_w),
        .evt_zero(evt_zero), .evt_prd(evt_prd),
        .evt_cup(evt_cmp_up), .evt_cdn(evt_cmp_dn),
        .pwm(pwm_out)
    );

    assign dir_up = rising_w;
endmodule

// File: rtl/pwm_timebase_aq_chk.sv
module pwm_timebase_aq_chk
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] cmp_act,
    input logic             pwm,
    input logic             evt_zero,
    input logic             evt_prd,
    input logic             evt_cup,
    input logic             evt_cdn
);
    p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP && $past(mode) == MODE_UP && !$stable(cnt))
        |-> (cnt - $past(cnt) == CNT_W'(1) || cnt == '0));

    p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN && $past(mode) == MODE_DOWN && !$stable(cnt))
        |-> ($past(cnt) - cnt == CNT_W'(1) || cnt == prd_act));

    p_no_fall_cmp_in_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_UP) |-> !evt_cdn);

    p_shadow_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(prd_act) || !$stable(cmp_act))
        |-> (cnt == '0 || $past(mode) == MODE_FREEZE));

    p_out_after_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm) |-> $past(evt_zero || evt_prd || evt_cup || evt_cdn));

    p_event_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero || evt_prd || evt_cup || evt_cdn) |-> $past(tick));
endmodule

bind pwm_timebase_aq pwm_timebase_aq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .tick(tick_w),
    .cnt(cnt_out), .prd_act(prd_act_w), .cmp_act(cmp_act_w),
    .pwm(pwm_out), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .evt_cup(evt_cmp_up), .evt_cdn(evt_cmp_dn)
);

// File: tb/pwm_timebase_aq_test.sv
module pwm_timebase_aq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] prd;
        logic [15:0] cmp;
        logic [7:0]  act;
        logic [15:0] win;
        logic [15:0] hi;
    } vec_t;

    // mode, period, compare, actions, window, expected high cycles
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd19, 16'd5,  8'h12, 16'd80, 16'd20},
        '{2'd0, 16'd19, 16'd10, 8'h12, 16'd80, 16'd40},
        '{2'd0, 16'd19, 16'd15, 8'h12, 16'd80, 16'd60},
        '{2'd0, 16'd19, 16'd0,  8'h12, 16'd80, 16'd0},
        '{2'd0, 16'd19, 16'd25, 8'h12, 16'd80, 16'd80},
        '{2'd2, 16'd10, 16'd4,  8'h60, 16'd80, 16'd48},
        '{2'd1, 16'd19, 16'd5,  8'h48, 16'd80, 16'd56},
        '{2'd0, 16'd9,  16'd3,  8'h03, 16'd80, 16'd40},
        '{2'd0, 16'd7,  16'd0,  8'h06, 16'd80, 16'd70}
    };
    string vtag [NV] = '{"R7 duty 25", "R7 duty 50", "R7 duty 75", "R9 compare over zero",
                         "R7 compare above period", "R5 updown duty", "R4 down duty",
                         "R6 toggle", "R9 hold no override"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prd_wr = 1'b0, cmp_wr = 1'b0, mode_wr = 1'b0, act_wr = 1'b0, div_wr = 1'b0;
    logic [15:0] prd_wdata = '0, cmp_wdata = '0;
    logic [1:0]  mode_wdata = '0;
    logic [7:0]  act_wdata = '0;
    logic [5:0]  div_wdata = '0;
    logic        pwm_out, dir_up, evt_zero, evt_prd, evt_cmp_up, evt_cmp_dn;
    logic [15:0] cnt_out;

    int n_checks = 0;
    int n_fail = 0;

    pwm_timebase_aq uut (
        .clk(clk), .rst_n(rst_n),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .act_wr(act_wr), .act_wdata(act_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .pwm_out(pwm_out), .cnt_out(cnt_out), .dir_up(dir_up),
        .evt_zero(evt_zero), .evt_prd(evt_prd),
        .evt_cmp_up(evt_cmp_up), .evt_cmp_dn(evt_cmp_dn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // 0 period, 1 compare, 2 mode, 3 actions, 4 divider
    task automatic wr(input int which, input logic [15:0] d);
        @(negedge clk);
        case (which)
            0: begin prd_wr = 1'b1;  prd_wdata = d; end
            1: begin cmp_wr = 1'b1;  cmp_wdata = d; end
            2: begin mode_wr = 1'b1; mode_wdata = d[1:0]; end
            3: begin act_wr = 1'b1;  act_wdata = d[7:0]; end
            default: begin div_wr = 1'b1; div_wdata = d[5:0]; end
        endcase
        @(negedge clk);
        {prd_wr, cmp_wr, mode_wr, act_wr, div_wr} = '0;
    endtask

    // 0 zero, 1 period, 2 any compare
    task automatic wait_evt(input int which);
        bit seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ((which == 0 && evt_zero) || (which == 1 && evt_prd) ||
                (which == 2 && (evt_cmp_up || evt_cmp_dn))) begin
                seen = 1'b1;
                break;
            end
        end
        if (!seen) chk("R2 event never seen", 0, 1);
    endtask

    task automatic zero_gap(output int gap);
        wait_evt(0);
        gap = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            gap++;
            if (evt_zero) break;
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [15:0] p, input logic [15:0] c,
                         input logic [7:0] a);
        do_reset();
        wr(4, 16'd0);
        wr(0, p);
        wr(1, c);
        wr(3, {8'd0, a});
        wr(2, {14'd0, m});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int gap;
        int hi;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset count", cnt_out, 0);
        chk("R1 reset output", pwm_out, 0);
        chk("R1 reset strobes", {evt_zero, evt_prd, evt_cmp_up, evt_cmp_dn}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 frozen after reset", cnt_out, 0);

        // R1/R2: default divider of 2
        wr(0, 16'd3);
        wr(2, 16'd0);
        zero_gap(gap);
        chk("R1 R2 default divide gap", gap, 8);

        // R2: exponent 1, factor code 3 -> 2*6 = 12
        do_reset();
        wr(4, 16'b011_001);
        wr(0, 16'd1);
        wr(2, 16'd0);
        zero_gap(gap);
        chk("R2 prescale product gap", gap, 24);

        // Vector table: duty over whole periods
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].mode, VECS[v].prd, VECS[v].cmp, VECS[v].act);
            repeat (60) @(negedge clk);
            hi = 0;
            for (int c = 0; c < int'(VECS[v].win); c++) begin
                @(negedge clk);
                if (pwm_out) hi++;
            end
            chk(vtag[v], hi, int'(VECS[v].hi));
        end

        // R3: rising mode rate and period arrival
        setup(2'd0, 16'd19, 16'd5, 8'h12);
        zero_gap(gap);
        chk("R3 up zero gap", gap, 20);
        wait_evt(1);
        chk("R3 period strobe count", cnt_out, 19);

        // R10: strobe with new count, output one clock later
        wait_evt(0);
        chk("R10 zero strobe count", cnt_out, 0);
        chk("R10 output before zero action", pwm_out, 0);
        @(negedge clk);
        chk("R10 output after zero action", pwm_out, 1);
        wait_evt(2);
        chk("R10 compare strobe count", cnt_out, 5);
        chk("R10 output before clear", pwm_out, 1);
        @(negedge clk);
        chk("R10 output after clear", pwm_out, 0);

        // R4: falling mode
        setup(2'd1, 16'd19, 16'd5, 8'h48);
        zero_gap(gap);
        chk("R4 down zero gap", gap, 20);
        wait_evt(0);
        @(negedge clk);
        chk("R4 reload after zero", cnt_out, 19);

        // R5: rising-then-falling
        setup(2'd2, 16'd10, 16'd4, 8'h60);
        zero_gap(gap);
        chk("R5 updown zero gap", gap, 20);
        wait_evt(1);
        chk("R5 turn count", cnt_out, 10);
        wait_evt(2);
        chk("R5 falling compare strobe", {evt_cmp_up, evt_cmp_dn}, 1);

        // R8: period write waits for the next zero
        setup(2'd0, 16'd19, 16'd30, 8'h00);
        wait_evt(1);
        repeat (5) @(negedge clk);
        wr(0, 16'd9);
        wait_evt(1);
        chk("R8 old period still active", cnt_out, 19);
        wait_evt(1);
        chk("R8 new period after zero", cnt_out, 9);

        summary();
        $finish;
    end
endmodule